// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial memory's bus front end and its storage array. During a write transaction the front end hands it a starting word address and then a series of data bytes. The bytes are parked in an eight-slot page buffer rather than going straight to the array. Only the low three address bits step from byte to byte, so a burst never leaves its page. A burst of more than eight bytes wraps around inside the page and overwrites the slots it has already filled.

When the front end reports a STOP, the block starts a self-timed write cycle. It raises `busy` for a fixed number of clock cycles, set by `CYCLE_CLKS`; the default is 2 ms at 50 MHz. In the first cycles of that period it streams every loaded slot to the array write port.

A write-protect pin suppresses all array writes. A STOP that finds the buffer empty, or that arrives while protect is high, starts no cycle. While the block is busy, all front-end strobes are ignored.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset `busy` and `arr_we` are low and the slot buffer is empty.
- R2: A `txn_start` pulse loads `start_addr`. Each `byte_vld` outside the busy period stores `byte_data` in the slot given by the current low three address bits, then steps that index by one. The upper five address bits stay those of `start_addr` for every array write of the transaction.
- R3: The slot index wraps from 7 to 0. With more than eight bytes in one burst, a slot keeps the last byte stored in it.
- R4: `arr_we` is never high while `busy` is low, so nothing reaches the array before a STOP has been accepted.
- R5: A `stop` with at least one loaded slot and `wr_protect` low sets `busy` from the next cycle. `busy` then stays high for exactly `CYCLE_CLKS` cycles.
- R6: During a cycle, each loaded slot is written exactly once, in ascending slot order, at address {page, slot}. Unloaded slots are not written.
- R7: A `stop` with `wr_protect` high starts no cycle and discards the buffered bytes. `arr_we` is low whenever `wr_protect` is high.
- R8: A `stop` with no loaded slot leaves `busy` low and writes nothing.
- R9: `txn_start`, `byte_vld` and `stop` have no effect while `busy` is high.
- R10: The loaded-slot mask is cleared when a write cycle ends and on every accepted `txn_start`, so a later STOP writes only bytes loaded since then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Begins a write transaction; latches `start_addr` |
| start_addr | input | 8 | Starting word address |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | STOP received; requests commit |
| wr_protect | input | 1 | High blocks all array writes |
| busy | output | 1 | High during the self-timed write cycle |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write enable |

## Verification
The commit path is exercised with several kinds of burst:
- A single byte shows the basic address placement.
- Exactly eight bytes from a mid-page start show the wrap of the low bits without any overwrite.
- Eleven and more bytes show that the last byte into a slot is the one kept.
- Random bursts of zero to twelve bytes, from random addresses and with protect sometimes high, test the page mask against a bench memory model.

Further directed cases separate the remaining rules:
- An empty STOP distinguishes "nothing to commit" from a real cycle.
- A protected STOP followed by a plain STOP shows the buffer was discarded.
- Strobes pulsed during a busy period, followed by a plain STOP, show that busy-time input changes nothing.
- A restarted transaction shows the mask is cleared on a new start.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic {
    PG_IDLE   = 1'b0,
    PG_COMMIT = 1'b1
  } pg_state_e;

endpackage

// File: rtl/pgbuf_slots.sv
module pgbuf_slots #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int SLOTS = 8,
  localparam int IW   = $clog2(SLOTS),
  localparam int PW   = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_i,
  input  logic [AW-1:0] addr_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          clear_i,
  input  logic          busy_i,
  input  logic [IW-1:0] rd_slot_i,
  output logic [PW-1:0] page_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_vld_o,
  output logic          any_vld_o
);

  logic [IW-1:0]    idx_q, idx_d, idx_base;
  logic [PW-1:0]    page_q, page_d;
  logic [SLOTS-1:0] mask_q, mask_d, mask_base;
  logic [SLOTS-1:0] wen;
  logic [DW-1:0]    slot_q [SLOTS];

  always_comb begin
    idx_base  = txn_i ? addr_i[IW-1:0] : idx_q;
    mask_base = txn_i ? '0 : mask_q;
    page_d    = txn_i ? addr_i[AW-1:IW] : page_q;
    idx_d     = idx_base;
    mask_d    = mask_base;
    if (load_i) begin
      mask_d[idx_base] = 1'b1;
      idx_d            = idx_base + IW'(1);
    end
    if (clear_i) mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      page_q <= '0;
      mask_q <= '0;
    end else begin
      idx_q  <= idx_d;
      page_q <= page_d;
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign wen[g] = load_i && (idx_base == IW'(g));
    always_ff @(posedge clk) begin
      if (wen[g]) slot_q[g] <= data_i;
    end
  end

  assign page_o    = page_q;
  assign rd_data_o = slot_q[rd_slot_i];
  assign rd_vld_o  = mask_q[rd_slot_i];
  assign any_vld_o = |mask_q;

  // R3: the index wraps to slot 0 after the last slot
  a_r3_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !txn_i && (idx_q == IW'(SLOTS-1)) |=> idx_q == '0);

  // R9: the mask does not move during a busy period unless it is being cleared
  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && !clear_i |=> $stable(mask_q));

  // R10: a new transaction without a byte leaves an empty mask
  a_r10_txn_clears: assert property (@(posedge clk) disable iff (!rst_n)
    txn_i && !load_i |=> mask_q == '0);

endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int CYCLE_CLKS = 100000,
  localparam int CW        = $clog2(CYCLE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);

  localparam logic [CW-1:0] LAST = CW'(CYCLE_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (!run_i || at_last) cnt_d = '0;
    else                   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign done_o = run_i && at_last;

  // R5: the count never passes the programmed cycle length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> cnt_q <= LAST);

endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int CW         = 17,
  localparam int IW        = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_i,
  input  logic          bvld_i,
  input  logic          stop_i,
  input  logic          wp_i,
  input  logic          any_vld_i,
  input  logic [CW-1:0] tmr_cnt_i,
  input  logic          tmr_done_i,
  output logic          busy_o,
  output logic          tmr_run_o,
  output logic          acc_txn_o,
  output logic          acc_load_o,
  output logic          clr_mask_o,
  output logic          scan_act_o,
  output logic [IW-1:0] scan_slot_o
);

  localparam logic [CW-1:0] SCAN_END = CW'(SLOTS);

  pg_state_e state_q, state_d;
  logic      idle;

  assign idle = (state_q == PG_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PG_IDLE:   if (stop_i && any_vld_i && !wp_i) state_d = PG_COMMIT;
      PG_COMMIT: if (tmr_done_i)                   state_d = PG_IDLE;
      default:                                     state_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PG_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o      = !idle;
  assign tmr_run_o   = !idle;
  assign acc_txn_o   = idle && txn_i;
  assign acc_load_o  = idle && bvld_i;
  assign clr_mask_o  = (!idle && tmr_done_i) || (idle && stop_i && wp_i);
  assign scan_act_o  = !idle && (tmr_cnt_i < SCAN_END);
  assign scan_slot_o = tmr_cnt_i[IW-1:0];

  // R5: the cycle holds until the timer reports completion
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && !tmr_done_i |=> !idle);

  // R5: each cycle starts with the timer at zero
  a_r5_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    idle && stop_i && any_vld_i && !wp_i |=> tmr_cnt_i == '0);

  // R7: a protected STOP starts no cycle
  a_r7_wp_stop_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    idle && stop_i && wp_i |=> idle);

  // R8: an empty STOP starts no cycle
  a_r8_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    idle && stop_i && !any_vld_i |=> idle);

endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int SLOTS      = 8,
  parameter int CYCLE_CLKS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_start,
  input  logic [AW-1:0] start_addr,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          stop,
  input  logic          wr_protect,
  output logic          busy,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          arr_we
);

  localparam int IW = $clog2(SLOTS);
  localparam int PW = AW - IW;
  localparam int CW = $clog2(CYCLE_CLKS);

  logic          acc_txn, acc_load, clr_mask, any_vld;
  logic          tmr_run, tmr_done, scan_act, rd_vld;
  logic [CW-1:0] tmr_cnt;
  logic [IW-1:0] scan_slot;
  logic [PW-1:0] page;
  logic [DW-1:0] rd_data;

  pgbuf_ctrl #(.SLOTS(SLOTS), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_i       (txn_start),
    .bvld_i      (byte_vld),
    .stop_i      (stop),
    .wp_i        (wr_protect),
    .any_vld_i   (any_vld),
    .tmr_cnt_i   (tmr_cnt),
    .tmr_done_i  (tmr_done),
    .busy_o      (busy),
    .tmr_run_o   (tmr_run),
    .acc_txn_o   (acc_txn),
    .acc_load_o  (acc_load),
    .clr_mask_o  (clr_mask),
    .scan_act_o  (scan_act),
    .scan_slot_o (scan_slot)
  );

  pgbuf_slots #(.AW(AW), .DW(DW), .SLOTS(SLOTS)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_i     (acc_txn),
    .addr_i    (start_addr),
    .load_i    (acc_load),
    .data_i    (byte_data),
    .clear_i   (clr_mask),
    .busy_i    (busy),
    .rd_slot_i (scan_slot),
    .page_o    (page),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  pgbuf_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (tmr_run),
    .cnt_o  (tmr_cnt),
    .done_o (tmr_done)
  );

  assign arr_we    = scan_act && rd_vld && !wr_protect;
  assign arr_addr  = {page, scan_slot};
  assign arr_wdata = rd_data;

  // R4: no array write outside a write cycle
  a_r4_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R2: the page bits hold still for the whole write cycle
  a_r2_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(arr_addr[AW-1:IW]));

  // R1: the outputs are quiet on the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !arr_we);

endmodule

// File: tb/pgbuf_commit_tb.sv
module pgbuf_commit_tb;

  localparam int CYC = 20;

  logic       clk, rst_n;
  logic       txn_start, byte_vld, stop, wr_protect;
  logic [7:0] start_addr, byte_data;
  logic       busy, arr_we;
  logic [7:0] arr_addr, arr_wdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_obs [256];
  logic [7:0] mem_exp [256];
  logic [7:0] e_buf [8];
  logic [7:0] e_mask;
  logic [4:0] e_page;
  logic [2:0] e_idx;

  int wr_cnt, order_bad, wp_bad, idle_bad, last_slot;
  bit poke;

  pgbuf_commit #(.CYCLE_CLKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop),
    .wr_protect(wr_protect), .busy(busy), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_we(arr_we)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [7:0] m);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic int mem_diffs();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem_obs[i] !== mem_exp[i]) n++;
    return n;
  endfunction

  // array-side monitor
  always @(negedge clk) begin
    if (rst_n && arr_we === 1'b1) begin
      mem_obs[arr_addr] = arr_wdata;
      wr_cnt++;
      if (int'(arr_addr[2:0]) <= last_slot) order_bad++;
      if (arr_addr[7:3] !== e_page) order_bad++;
      last_slot = int'(arr_addr[2:0]);
      if (wr_protect) wp_bad++;
      if (!busy) idle_bad++;
    end
  end

  task automatic begin_txn(input logic [7:0] a);
    txn_start = 1'b1; start_addr = a;
    @(negedge clk);
    txn_start = 1'b0;
    e_page = a[7:3]; e_idx = a[2:0]; e_mask = '0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
    e_buf[e_idx] = d; e_mask[e_idx] = 1'b1; e_idx = e_idx + 3'd1;
  endtask

  task automatic finish(input bit wp, input string tag);
    int n, exp_len, exp_wr;
    chk(wr_cnt == 0 && busy === 1'b0, {tag, " R4 idle before stop"}, wr_cnt, 0);
    wr_cnt = 0; last_slot = -1;
    exp_len = (!wp && e_mask != 0) ? CYC : 0;
    exp_wr  = exp_len != 0 ? popc(e_mask) : 0;
    if (exp_len != 0)
      for (int i = 0; i < 8; i++) if (e_mask[i]) mem_exp[{e_page, 3'(i)}] = e_buf[i];
    wr_protect = wp; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    n = 0;
    while (busy === 1'b1 && n < CYC + 5) begin
      n++;
      if (poke && n == 3) begin
        txn_start = 1'b1; byte_vld = 1'b1; stop = 1'b1;
        start_addr = 8'($urandom); byte_data = 8'($urandom);
      end else begin
        txn_start = 1'b0; byte_vld = 1'b0; stop = 1'b0;
      end
      @(negedge clk);
    end
    txn_start = 1'b0; byte_vld = 1'b0; stop = 1'b0;
    wr_protect = 1'b0;
    chk(n == exp_len, {tag, " R5 busy length"}, n, exp_len);
    chk(wr_cnt == exp_wr, {tag, " R6 write count"}, wr_cnt, exp_wr);
    chk(mem_diffs() == 0, {tag, " R2 R3 array contents"}, mem_diffs(), 0);
    e_mask = '0;
    wr_cnt = 0;
  endtask

  initial begin
    int nb;
    bit wp;
    logic [7:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mem_obs[i] = 8'h00; mem_exp[i] = 8'h00; end
    wr_cnt = 0; order_bad = 0; wp_bad = 0; idle_bad = 0; last_slot = -1; poke = 0;
    e_mask = '0; e_page = '0; e_idx = '0;
    txn_start = 0; byte_vld = 0; stop = 0; wr_protect = 0;
    start_addr = 0; byte_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && arr_we === 1'b0, "R1 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && arr_we === 1'b0, "R1 after release", int'(arr_we), 0);
    // R1: empty buffer after reset, STOP does nothing
    finish(1'b0, "R1 R8 stop after reset");

    // R2: single byte
    begin_txn(8'h35); put_byte(8'hA5); finish(1'b0, "R2 byte write");
    // R3: exactly eight from mid page
    begin_txn(8'h44);
    for (int i = 0; i < 8; i++) put_byte(8'(8'h10 + i));
    finish(1'b0, "R3 full page");
    // R3: eleven bytes overwrite
    begin_txn(8'h9E);
    for (int i = 0; i < 11; i++) put_byte(8'(8'hC0 + i));
    finish(1'b0, "R3 overflow");
    // R8: transaction with no bytes
    begin_txn(8'h20); finish(1'b0, "R8 empty stop");
    // R7: protected stop, then bytes discarded
    begin_txn(8'h60); put_byte(8'h77); put_byte(8'h88);
    finish(1'b1, "R7 protected");
    finish(1'b0, "R7 discarded");
    // R9: strobes during busy ignored, R10 mask cleared at end
    begin_txn(8'hB0); put_byte(8'h5A);
    poke = 1; finish(1'b0, "R9 poke cycle"); poke = 0;
    finish(1'b0, "R9 R10 stop after cycle");
    // R10: restart clears mask
    begin_txn(8'hD0); put_byte(8'h01); put_byte(8'h02); put_byte(8'h03);
    begin_txn(8'hE5); put_byte(8'hEE);
    finish(1'b0, "R10 restart");

    // random transactions
    for (int t = 0; t < 40; t++) begin
      a  = 8'($urandom);
      nb = int'($urandom % 13);
      wp = ($urandom % 5) == 0;
      begin_txn(a);
      for (int k = 0; k < nb; k++) put_byte(8'($urandom));
      finish(wp, "R2 R3 R6 R7 random");
    end

    chk(order_bad == 0, "R6 slot order and page", order_bad, 0);
    chk(wp_bad == 0, "R7 write under protect", wp_bad, 0);
    chk(idle_bad == 0, "R4 write while idle", idle_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule